// File: doc/BRIEF.md
# Randomized PWM parameter generator

This block supplies a PWM core with fresh timing parameters for every switching period. Each time the core strobes a request, the block advances a 32-bit multiplicative congruential generator. It turns the new word into a period count inside a configured integer range and a high-time count proportional to that period. It can also produce a random tick length that stretches each counter step. None of the range mapping uses a divider. A slice of the word is multiplied by the range width at full precision, then shifted back down by the slice width.

Two range (minimum, width) pairs are available. With dual-range mode on, a random bit picks one of them for each period, which shapes the distribution of switching frequencies. The results appear on registered outputs with a one-cycle valid pulse at a fixed latency. That latency is well below any useful period length, so the core can request the next set at the start of the current period.

Top module: `rpwm_param_gen`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and period_o, high_o and tick_o are 0. The generator word is reset to 17.
- R2: Each cycle with req_i high advances the generator word w to (17·w) mod 2^32, so the first request after reset uses word 289. Cycles without a request leave the word unchanged.
- R3: If req_i is high at rising edge t, valid_o is high between edges t+2 and t+3, together with that request's results. Requests on consecutive cycles each yield one result, in order.
- R4: With b = min(scale_bits_i, 32), beta is w >> (32−b), and beta is 0 when b is 0. The offset is (beta·width) >> b, using a full-width product. The period is min + offset, which lies in [min, min+width−1]. A width of 0 gives exactly min.
- R5: With dual_en_i low, the period always uses range A (min_a_i, width_a_i).
- R6: With dual_en_i high, bit 31 of (17·w) mod 2^32 selects the range: 1 picks range B (min_b_i, width_b_i) and 0 picks range A.
- R7: high_o equals (duty_i·period_o) >> 8, where duty_i is an 8-bit coefficient in units of 1/256.
- R8: With rtick_en_i high, tick_o is tick_min_i + ((beta_t·tick_width_i) >> b), where beta_t is formed as in R4 from (289·w) mod 2^32. With rtick_en_i low, tick_o is 1.
- R9: Without a request, valid_o stays low and period_o, high_o and tick_o hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe for one new parameter set |
| dual_en_i | input | 1 | Random choice between range A and range B |
| min_a_i | input | CNT_W | Range A minimum period count |
| width_a_i | input | CNT_W | Range A width (number of values) |
| min_b_i | input | CNT_W | Range B minimum period count |
| width_b_i | input | CNT_W | Range B width |
| duty_i | input | 8 | Duty coefficient, high time = period·duty/256 |
| scale_bits_i | input | 6 | Width b of the random slice, clamped to 32 |
| rtick_en_i | input | 1 | Random tick length enable |
| tick_min_i | input | TICK_W | Minimum tick length |
| tick_width_i | input | TICK_W | Tick length range width |
| valid_o | output | 1 | One-cycle pulse marking a new result |
| period_o | output | CNT_W | Period count |
| high_o | output | CNT_W | High-time count |
| tick_o | output | TICK_W | Tick length in clock cycles |

## Verification
For a request sampled at one rising edge, the period, high-time and tick results all become visible together after the second following edge. The driver records the cycle count at the falling edge where it raises req_i. The monitor pops the matching expectation only at the falling edge where valid_o is high, and it demands that the cycle count there be exactly three more than the recorded one. A valid pulse with no pending expectation fails. Idle stretches then confirm that the registered outputs hold their values.

// File: rtl/rpwm_pkg.sv
package rpwm_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [WORD_W-1:0] LCG_SEED = 32'd17;
  localparam logic [WORD_W-1:0] LCG_MULT = 32'd17;
  localparam int unsigned DUTY_W = 8;
  localparam int unsigned SCALE_W = 6;
  localparam int unsigned N_RANGES = 2;
endpackage

// File: rtl/rpwm_lcg.sv
module rpwm_lcg
  import rpwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  output logic [WORD_W-1:0] word_o,
  output logic [WORD_W-1:0] next1_o,
  output logic [WORD_W-1:0] next2_o
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= LCG_SEED;
    else if (step_i) word_q <= next1_o;
  end

  // modulo 2^32 comes from truncation
  always_comb begin
    next1_o = word_q * LCG_MULT;
    next2_o = next1_o * LCG_MULT;
  end

  assign word_o = word_q;

  p_lcg_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> word_o == WORD_W'($past(word_o) * 32'd17));
  p_lcg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(word_o));
endmodule

// File: rtl/rpwm_range_map.sv
module rpwm_range_map
  import rpwm_pkg::*;
#(
  parameter int unsigned VAL_W = 16
) (
  input  logic [WORD_W-1:0]  word_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [VAL_W-1:0]   min_i,
  input  logic [VAL_W-1:0]   width_i,
  output logic [VAL_W-1:0]   value_o
);
  localparam int unsigned PROD_W = WORD_W + VAL_W;

  logic [SCALE_W-1:0] b_eff;
  logic [WORD_W-1:0]  beta;
  logic [PROD_W-1:0]  prod;
  logic [PROD_W-1:0]  offset;

  always_comb begin
    b_eff = (scale_i > SCALE_W'(WORD_W)) ? SCALE_W'(WORD_W) : scale_i;
    if (b_eff == '0) beta = '0;
    else             beta = word_i >> (SCALE_W'(WORD_W) - b_eff);
    prod    = PROD_W'(beta) * PROD_W'(width_i);
    offset  = prod >> b_eff;
    value_o = min_i + offset[VAL_W-1:0];
  end
endmodule

// File: rtl/rpwm_duty_scale.sv
module rpwm_duty_scale
  import rpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0]  period_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [CNT_W-1:0]  high_o
);
  localparam int unsigned PROD_W = CNT_W + DUTY_W;

  logic [PROD_W-1:0] prod;

  always_comb begin
    prod   = PROD_W'(period_i) * PROD_W'(duty_i);
    high_o = prod[PROD_W-1:DUTY_W];
  end
endmodule

// File: rtl/rpwm_param_gen.sv
module rpwm_param_gen
  import rpwm_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned TICK_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               dual_en_i,
  input  logic [CNT_W-1:0]   min_a_i,
  input  logic [CNT_W-1:0]   width_a_i,
  input  logic [CNT_W-1:0]   min_b_i,
  input  logic [CNT_W-1:0]   width_b_i,
  input  logic [DUTY_W-1:0]  duty_i,
  input  logic [SCALE_W-1:0] scale_bits_i,
  input  logic               rtick_en_i,
  input  logic [TICK_W-1:0]  tick_min_i,
  input  logic [TICK_W-1:0]  tick_width_i,
  output logic               valid_o,
  output logic [CNT_W-1:0]   period_o,
  output logic [CNT_W-1:0]   high_o,
  output logic [TICK_W-1:0]  tick_o
);
  localparam int unsigned EXT_W = CNT_W + 1;

  logic [WORD_W-1:0] word, next1, next2;
  logic [CNT_W-1:0]  min_arr   [N_RANGES];
  logic [CNT_W-1:0]  width_arr [N_RANGES];
  logic [CNT_W-1:0]  cand      [N_RANGES];
  logic              sel_b;
  logic [CNT_W-1:0]  period_d;
  logic [TICK_W-1:0] tick_map, tick_d;
  logic [CNT_W-1:0]  high_d;

  logic              s1_q, s2_q;
  logic [CNT_W-1:0]  period_s2_q;
  logic [TICK_W-1:0] tick_s2_q;

  rpwm_lcg u_lcg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (req_i),
    .word_o (word),
    .next1_o(next1),
    .next2_o(next2)
  );

  assign min_arr[0]   = min_a_i;
  assign width_arr[0] = width_a_i;
  assign min_arr[1]   = min_b_i;
  assign width_arr[1] = width_b_i;

  for (genvar g = 0; g < N_RANGES; g++) begin : g_range
    rpwm_range_map #(.VAL_W(CNT_W)) u_map (
      .word_i (word),
      .scale_i(scale_bits_i),
      .min_i  (min_arr[g]),
      .width_i(width_arr[g]),
      .value_o(cand[g])
    );
  end

  rpwm_range_map #(.VAL_W(TICK_W)) u_tick_map (
    .word_i (next2),
    .scale_i(scale_bits_i),
    .min_i  (tick_min_i),
    .width_i(tick_width_i),
    .value_o(tick_map)
  );

  // select bit comes from the following word, not the period slice
  always_comb begin
    sel_b    = dual_en_i & next1[WORD_W-1];
    period_d = sel_b ? cand[1] : cand[0];
    tick_d   = rtick_en_i ? tick_map : TICK_W'(1);
  end

  rpwm_duty_scale #(.CNT_W(CNT_W)) u_duty (
    .period_i(period_s2_q),
    .duty_i  (duty_i),
    .high_o  (high_d)
  );

  // stage 1: word advanced; stage 2: range mapped; stage 3: duty and output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q        <= 1'b0;
      s2_q        <= 1'b0;
      period_s2_q <= '0;
      tick_s2_q   <= '0;
    end else begin
      s1_q <= req_i;
      s2_q <= s1_q;
      if (s1_q) begin
        period_s2_q <= period_d;
        tick_s2_q   <= tick_d;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      period_o <= '0;
      high_o   <= '0;
      tick_o   <= '0;
    end else begin
      valid_o <= s2_q;
      if (s2_q) begin
        period_o <= period_s2_q;
        high_o   <= high_d;
        tick_o   <= tick_s2_q;
      end
    end
  end

  function automatic logic in_range(input logic [CNT_W-1:0] v,
                                    input logic [CNT_W-1:0] mn,
                                    input logic [CNT_W-1:0] wd);
    logic [EXT_W-1:0] hi;
    hi = (wd == '0) ? EXT_W'(mn) : EXT_W'(mn) + EXT_W'(wd) - EXT_W'(1);
    return (v >= mn) && (EXT_W'(v) <= hi);
  endfunction

  p_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> ##3 valid_o);
  p_no_spurious_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(req_i, 3));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(period_o) && $stable(high_o) && $stable(tick_o));
  p_range_a_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !dual_en_i |-> in_range(period_o, min_a_i, width_a_i));
  p_range_dual_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && dual_en_i |->
      in_range(period_o, min_a_i, width_a_i) || in_range(period_o, min_b_i, width_b_i));
  p_high_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> high_o <= period_o);
  p_tick_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !rtick_en_i |-> tick_o == TICK_W'(1));
  p_tick_floor_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && rtick_en_i |-> tick_o >= tick_min_i);
endmodule

// File: tb/rpwm_param_gen_test.sv
`timescale 1ns/1ps
module rpwm_param_gen_test;
  localparam int CNT_W  = 16;
  localparam int TICK_W = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0;
  logic              dual_en_i = 1'b0;
  logic [CNT_W-1:0]  min_a_i = '0, width_a_i = '0, min_b_i = '0, width_b_i = '0;
  logic [7:0]        duty_i = '0;
  logic [5:0]        scale_bits_i = '0;
  logic              rtick_en_i = 1'b0;
  logic [TICK_W-1:0] tick_min_i = '0, tick_width_i = '0;
  logic              valid_o;
  logic [CNT_W-1:0]  period_o, high_o;
  logic [TICK_W-1:0] tick_o;

  rpwm_param_gen #(.CNT_W(CNT_W), .TICK_W(TICK_W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .dual_en_i(dual_en_i),
    .min_a_i(min_a_i), .width_a_i(width_a_i), .min_b_i(min_b_i), .width_b_i(width_b_i),
    .duty_i(duty_i), .scale_bits_i(scale_bits_i), .rtick_en_i(rtick_en_i),
    .tick_min_i(tick_min_i), .tick_width_i(tick_width_i),
    .valid_o(valid_o), .period_o(period_o), .high_o(high_o), .tick_o(tick_o)
  );

  always #10 clk_i = ~clk_i;

  typedef struct {
    longint unsigned period;
    longint unsigned high;
    longint unsigned tick;
    longint          due;
    string           tag;
  } exp_t;

  exp_t            q[$];
  int              n_chk = 0;
  int              n_fail = 0;
  longint          cyc = 0;
  logic [31:0]     mw = 32'd17;
  longint unsigned last_period = 0;
  bit              done = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint unsigned act,
                     input longint unsigned expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic longint unsigned map_val(input logic [31:0] w, input int b,
      input longint unsigned mn, input longint unsigned wd, input int vw);
    longint unsigned beta, off;
    int bb;
    bb = (b > 32) ? 32 : b;
    beta = (bb == 0) ? 0 : (longint'(w) >> (32 - bb));
    off = (beta * wd) >> bb;
    return (mn + off) & ((64'd1 << vw) - 1);
  endfunction

  task automatic push_exp(input string tag);
    exp_t e;
    logic [31:0] n1, n2;
    longint unsigned p;
    mw = mw * 32'd17;
    n1 = mw * 32'd17;
    n2 = n1 * 32'd17;
    if (dual_en_i && n1[31])
      p = map_val(mw, scale_bits_i, min_b_i, width_b_i, CNT_W);
    else
      p = map_val(mw, scale_bits_i, min_a_i, width_a_i, CNT_W);
    e.period = p;
    e.high   = (p * duty_i) >> 8;
    e.tick   = rtick_en_i ? map_val(n2, scale_bits_i, tick_min_i, tick_width_i, TICK_W) : 1;
    e.due    = cyc + 3;
    e.tag    = tag;
    q.push_back(e);
  endtask

  task automatic do_req(input int n, input int gap, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      req_i = 1'b1;
      push_exp(tag);
    end
    @(negedge clk_i);
    req_i = 1'b0;
    repeat (gap) @(negedge clk_i);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  // monitor: scoreboard pop on every valid pulse
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (q.size() == 0) begin
        chk(1'b0, "R9 unexpected valid", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(cyc == e.due, {e.tag, " R3 latency"}, cyc, e.due);
        chk(period_o == e.period, {e.tag, " period"}, period_o, e.period);
        chk(high_o == e.high, {e.tag, " R7 high"}, high_o, e.high);
        chk(tick_o == e.tick, {e.tag, " tick"}, tick_o, e.tick);
        last_period = period_o;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(valid_o == 1'b0, "R1 valid", valid_o, 0);
    chk(period_o == 0, "R1 period", period_o, 0);
    chk(high_o == 0, "R1 high", high_o, 0);
    chk(tick_o == 0, "R1 tick", tick_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R2 R4 R5 R7 R8: single range, wide spread, tick off -> 1
    min_a_i = 333; width_a_i = 668; min_b_i = 600; width_b_i = 50;
    duty_i = 128; scale_bits_i = 23;
    for (int i = 0; i < 12; i++) do_req(1, 4, "R2 R4 R5 single");
    drain();

    // R3: requests on consecutive cycles
    duty_i = 77;
    do_req(4, 2, "R3 back-to-back");
    drain();

    // R6: dual range selection
    dual_en_i = 1'b1;
    min_a_i = 500; width_a_i = 500; min_b_i = 333; width_b_i = 167; duty_i = 200;
    for (int i = 0; i < 12; i++) do_req(1, 3, "R6 dual");
    drain();
    dual_en_i = 1'b0;

    // R8: random tick 7..13
    rtick_en_i = 1'b1; tick_min_i = 7; tick_width_i = 7;
    min_a_i = 34; width_a_i = 34; duty_i = 255;
    for (int i = 0; i < 10; i++) do_req(1, 3, "R8 tick");
    drain();

    // R4 boundaries: b=0, b=32, b clamped, width 0, other b
    scale_bits_i = 0;  do_req(2, 3, "R4 scale0");
    scale_bits_i = 32; do_req(3, 3, "R4 scale32");
    scale_bits_i = 45; do_req(3, 3, "R4 clamp");
    scale_bits_i = 10; width_a_i = 0; do_req(3, 3, "R4 width0");
    width_a_i = 1000; duty_i = 0; do_req(3, 3, "R7 duty0");
    drain();

    // R9: idle, no valid and outputs hold
    repeat (20) @(negedge clk_i);
    chk(valid_o == 1'b0, "R9 idle valid", valid_o, 0);
    chk(period_o == last_period, "R9 hold period", period_o, last_period);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule